// File: doc/BRIEF.md
# Single-Wire Bus Device Slot Decoder

This block is the device end of a single-wire, open-drain bus with one master. It watches the shared line through a two-flop synchronizer and measures how long each low period lasts. A low period that reaches the reset threshold is a bus reset. Once the master lets the line rise again, the block waits a programmable gap and then pulls the line low for a programmable time. This low pulse tells the master that a device is present. From then on, every falling edge made by the master opens one bit slot.

A mode input picks what a slot means. In receive mode the block samples the line a fixed time after the edge, and the level it sees is the received bit. In transmit mode the block takes one bit from the upper layer. It pulls the line low for a fixed time to send a 0, and leaves the line alone to send a 1. The block only ever pulls the line low. It never drives it high. Bytes, commands and memory are handled by the layer above.

The data paths are valid-only. The line cannot be stalled, so there is no ready signal on either path. A received bit is on `rx_bit` only during the single cycle that `rx_valid` is high. The consumer must take it in that cycle, or the bit is lost. On the transmit side, `tx_mode` and `tx_bit` must already be stable when the master's falling edge arrives. The cycle in which the bit is taken is marked by a one-cycle `tx_taken` pulse.

Top module: `owire_slot_slave`

In the requirements, S is the synchronizer delay of 3 cycles, counted from the cycle in which `dq_in` changes. All other times are in clock cycles, each one the microsecond parameter multiplied by CLK_PER_US. The names are: RSTC for the reset threshold, PDHC for the presence gap, PDLC for the presence width, SMPC for the sample point and HLDC for the hold time of a sent 0.

## Requirements
- R1: During and after `rst_n` low, `dq_pull`, `rx_valid`, `tx_taken` and `bus_reset` are 0. Until the first bus reset, falling edges start no slots: there is no rx pulse, no take pulse and no pull.
- R2: A low period lasting RSTC cycles gives a one-cycle `bus_reset` pulse S+RSTC-1 cycles after `dq_in` falls. A low period shorter than RSTC gives no pulse.
- R3: After a bus reset, the line rising again sets `dq_pull`=1 (line driven low) S+PDHC cycles after the rise, and holds it for exactly PDLC cycles.
- R4: In receive mode (`tx_mode`=0), `rx_valid` is a one-cycle pulse S+SMPC cycles after the falling edge. `rx_bit` is the level of the line at that point: 1 for high, 0 for low.
- R5: In transmit mode (`tx_mode`=1) with `tx_bit`=0, `tx_taken` pulses and `dq_pull` rises S cycles after the falling edge. `dq_pull` stays high for HLDC cycles, so the line reads 0 at 15 µs into the slot.
- R6: In transmit mode with `tx_bit`=1, `tx_taken` still pulses but `dq_pull` stays 0, so the line reads 1 once the master lets go.
- R7: A bus reset overrides any slot or presence in progress. `dq_pull` is 0 while `bus_reset` is high. The presence sequence of R3 then follows, and slots work normally after it.
- R8: Each falling edge in the idle state makes exactly one rx or take pulse. Edges during the presence gap or presence pulse, and line activity before the line returns high, start no slot.
- R9: `dq_pull` is high only during the presence pulse or while a 0 is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dq_in | input | 1 | Level read from the bus line (asynchronous) |
| dq_pull | output | 1 | 1 = pull the bus line low; 0 = release it |
| tx_mode | input | 1 | Slot mode: 0 = receive (master writes), 1 = transmit (master reads) |
| tx_bit | input | 1 | Bit to send in the next transmit slot |
| tx_taken | output | 1 | One-cycle pulse: `tx_bit` was taken for this slot |
| rx_valid | output | 1 | One-cycle pulse: `rx_bit` holds a received bit |
| rx_bit | output | 1 | Received bit, valid while `rx_valid` is high |
| bus_reset | output | 1 | One-cycle pulse when a bus reset is recognized |

## Verification
Every result is due a fixed number of cycles after the stimulus that causes it. `bus_reset` is due at S+RSTC-1. The presence rise is due at S+PDHC after the rise of the line, and the presence lasts PDLC cycles. The rx pulse is due at S+SMPC, and the take pulse and the rise of a sent 0 are due at S. Each directed task changes the master's line on a falling clock edge and then counts falling edges until the output moves. It compares that count with the exact value derived from the requirements, so an early or late result fails just as a missing one does. Pulse counters that run on the rising clock edge confirm that each slot produced exactly one pulse, and that edges that should be ignored produced none.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [2:0] {
    ST_OFFLINE,   // no bus reset seen yet
    ST_IN_RST,    // line held in reset, wait for release
    ST_PDH,       // gap before presence
    ST_PDL,       // presence pulse driven
    ST_IDLE,      // waiting for a slot edge
    ST_WRITE,     // master-to-device slot, sampling pending
    ST_READ,      // device-to-master slot, bit being shown
    ST_RECOVER    // slot done, wait for line high
  } owire_state_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/owire_line_sync.sv
module owire_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dq_in,
  output logic line_o,
  output logic fall_o,
  output logic rise_o
);

  // stage STAGES holds the previous synchronized level
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= dq_in;
  end

  generate
    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign line_o = chain[STAGES-1];
  assign fall_o = chain[STAGES] & ~chain[STAGES-1];
  assign rise_o = ~chain[STAGES] & chain[STAGES-1];

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);  // R8

endmodule

// File: rtl/owire_low_meter.sv
module owire_low_meter #(
  parameter int RST_CYC = 960
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rst_hit_o
);

  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RST_CYC);
  localparam logic [CW-1:0] LAST  = CW'(RST_CYC - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_cnt <= '0;
    else if (line_i)         low_cnt <= '0;
    else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
  end

  // fires once, on the cycle the low run completes the threshold
  assign rst_hit_o = ~line_i & (low_cnt == LAST);

  AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    line_i |=> (low_cnt == '0));  // R2
  AST_LOW_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_i && low_cnt == LIMIT) |=> (low_cnt == LIMIT || low_cnt == '0));  // R2

endmodule

// File: rtl/owire_slot_fsm.sv
module owire_slot_fsm
  import owire_pkg::*;
#(
  parameter int PDH_CYC  = 60,
  parameter int PDL_CYC  = 240,
  parameter int SMP_CYC  = 60,
  parameter int HLD_CYC  = 60,
  parameter int TW       = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic fall_i,
  input  logic rise_i,
  input  logic rst_hit_i,
  input  logic tx_mode,
  input  logic tx_bit,
  output logic dq_pull,
  output logic tx_taken,
  output logic rx_valid,
  output logic rx_bit,
  output logic bus_reset
);

  localparam logic [TW-1:0] PDH_END = TW'(PDH_CYC - 1);
  localparam logic [TW-1:0] PDL_END = TW'(PDL_CYC - 1);
  localparam logic [TW-1:0] SMP_END = TW'(SMP_CYC - 1);
  localparam logic [TW-1:0] HLD_END = TW'(HLD_CYC - 1);

  owire_state_e  state;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OFFLINE;
      tmr       <= '0;
      dq_pull   <= 1'b0;
      tx_taken  <= 1'b0;
      rx_valid  <= 1'b0;
      rx_bit    <= 1'b0;
      bus_reset <= 1'b0;
    end else begin
      tx_taken  <= 1'b0;
      rx_valid  <= 1'b0;
      bus_reset <= 1'b0;
      if (rst_hit_i) begin
        state     <= ST_IN_RST;
        dq_pull   <= 1'b0;
        bus_reset <= 1'b1;
        tmr       <= '0;
      end else begin
        unique case (state)
          ST_OFFLINE: ;
          ST_IN_RST: begin
            if (rise_i) begin
              state <= ST_PDH;
              tmr   <= '0;
            end
          end
          ST_PDH: begin
            if (tmr == PDH_END) begin
              state   <= ST_PDL;
              dq_pull <= 1'b1;
              tmr     <= '0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_PDL: begin
            if (tmr == PDL_END) begin
              state   <= ST_IDLE;
              dq_pull <= 1'b0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_IDLE: begin
            if (fall_i) begin
              tmr <= '0;
              if (tx_mode) begin
                state    <= ST_READ;
                dq_pull  <= ~tx_bit;
                tx_taken <= 1'b1;
              end else begin
                state <= ST_WRITE;
              end
            end
          end
          ST_WRITE: begin
            if (tmr == SMP_END) begin
              state    <= ST_RECOVER;
              rx_valid <= 1'b1;
              rx_bit   <= line_i;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_READ: begin
            if (tmr == HLD_END) begin
              state   <= ST_RECOVER;
              dq_pull <= 1'b0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_RECOVER: begin
            if (line_i) state <= ST_IDLE;
          end
          default: state <= ST_OFFLINE;
        endcase
      end
    end
  end

  AST_OFFLINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFFLINE) |-> (!rx_valid && !tx_taken && !dq_pull));  // R1
  AST_BUS_RESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !bus_reset);  // R2
  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);  // R4
  AST_RX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(state) == ST_WRITE));  // R4
  AST_TAKE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |-> (state == ST_READ));  // R5
  AST_RESET_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> (!dq_pull && state == ST_IN_RST));  // R7
  AST_PULL_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
    dq_pull |-> (state == ST_PDL || state == ST_READ));  // R9

endmodule

// File: rtl/owire_slot_slave.sv
module owire_slot_slave
  import owire_pkg::*;
#(
  parameter int CLK_PER_US  = 200,
  parameter int RST_MIN_US  = 480,
  parameter int PDH_US      = 30,
  parameter int PDL_US      = 120,
  parameter int SAMPLE_US   = 30,
  parameter int TX0_HOLD_US = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dq_in,
  output logic dq_pull,
  input  logic tx_mode,
  input  logic tx_bit,
  output logic tx_taken,
  output logic rx_valid,
  output logic rx_bit,
  output logic bus_reset
);

  localparam int RST_CYC = RST_MIN_US  * CLK_PER_US;
  localparam int PDH_CYC = PDH_US      * CLK_PER_US;
  localparam int PDL_CYC = PDL_US      * CLK_PER_US;
  localparam int SMP_CYC = SAMPLE_US   * CLK_PER_US;
  localparam int HLD_CYC = TX0_HOLD_US * CLK_PER_US;
  localparam int PH_MAX  = int'(max4(PDH_CYC, PDL_CYC, SMP_CYC, HLD_CYC));
  localparam int TW      = $clog2(PH_MAX + 1);

  logic line_s, fall_s, rise_s, rst_hit;

  owire_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .dq_in  (dq_in),
    .line_o (line_s),
    .fall_o (fall_s),
    .rise_o (rise_s)
  );

  owire_low_meter #(.RST_CYC(RST_CYC)) u_low (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (line_s),
    .rst_hit_o (rst_hit)
  );

  owire_slot_fsm #(
    .PDH_CYC (PDH_CYC),
    .PDL_CYC (PDL_CYC),
    .SMP_CYC (SMP_CYC),
    .HLD_CYC (HLD_CYC),
    .TW      (TW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (line_s),
    .fall_i    (fall_s),
    .rise_i    (rise_s),
    .rst_hit_i (rst_hit),
    .tx_mode   (tx_mode),
    .tx_bit    (tx_bit),
    .dq_pull   (dq_pull),
    .tx_taken  (tx_taken),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .bus_reset (bus_reset)
  );

  AST_RESET_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> !$past(line_s));  // R2

endmodule

// File: tb/owire_slot_slave_bench.sv
`timescale 1ns/1ps
module owire_slot_slave_bench;

  localparam int CPU   = 2;
  localparam int RST_C = 480 * CPU;
  localparam int PDH_C = 30 * CPU;
  localparam int PDL_C = 120 * CPU;
  localparam int SMP_C = 30 * CPU;
  localparam int HLD_C = 30 * CPU;
  localparam int SYNC  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic tx_mode = 1'b0;
  logic tx_bit = 1'b0;
  logic dq_line;
  logic dq_pull, tx_taken, rx_valid, rx_bit, bus_reset;

  always #2.5 clk = ~clk;

  assign dq_line = ~(m_low | dq_pull);

  owire_slot_slave #(.CLK_PER_US(CPU)) u_owire_slot_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .dq_in     (dq_line),
    .dq_pull   (dq_pull),
    .tx_mode   (tx_mode),
    .tx_bit    (tx_bit),
    .tx_taken  (tx_taken),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .bus_reset (bus_reset)
  );

  int n_chk = 0, n_bad = 0;
  int n_rx = 0, n_tx = 0, n_br = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (rx_valid)  n_rx <= n_rx + 1;
    if (tx_taken)  n_tx <= n_tx + 1;
    if (bus_reset) n_br <= n_br + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic pick(input int which);
    case (which)
      0: return bus_reset;
      1: return dq_pull;
      2: return rx_valid;
      default: return tx_taken;
    endcase
  endfunction

  task automatic wait_sig(input int which, input logic lvl, input int lim, output int c);
    c = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (pick(which) == lvl) begin
        c = i;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    int r0, t0;
    rst_n = 1'b0;
    tx_mode = 1'b1;
    tx_bit = 1'b0;
    idle(4);
    chk(!dq_pull && !rx_valid && !tx_taken && !bus_reset, "R1", "outputs in reset",
        {dq_pull, rx_valid, tx_taken, bus_reset}, 0);
    rst_n = 1'b1;
    idle(4);
    chk(!dq_pull && !rx_valid && !tx_taken && !bus_reset, "R1", "outputs after reset",
        {dq_pull, rx_valid, tx_taken, bus_reset}, 0);
    r0 = n_rx; t0 = n_tx;
    m_low = 1'b1;
    idle(4);
    m_low = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (dq_pull) chk(1'b0, "R1", "pull before bus reset", 1, 0);
    end
    chk(n_rx == r0 && n_tx == t0, "R1", "pulses before bus reset", (n_rx - r0) + (n_tx - t0), 0);
    tx_mode = 1'b0;
  endtask

  task automatic t_bus_reset(input string req);
    int c;
    m_low = 1'b1;
    wait_sig(0, 1'b1, RST_C + 50, c);
    chk(c == SYNC + RST_C - 1, "R2", {"bus_reset timing ", req}, c, SYNC + RST_C - 1);
    chk(!dq_pull, "R7", "pull released at bus reset", dq_pull, 0);
    idle(20);
    m_low = 1'b0;
    wait_sig(1, 1'b1, PDH_C + 40, c);
    chk(c == SYNC + PDH_C, "R3", "presence start", c, SYNC + PDH_C);
    wait_sig(1, 1'b0, PDL_C + 40, c);
    chk(c == PDL_C, "R3", "presence width", c, PDL_C);
    idle(10);
  endtask

  task automatic t_write(input logic b);
    int r0, got;
    logic gb;
    got = -1; gb = 1'bx;
    tx_mode = 1'b0;
    r0 = n_rx;
    m_low = 1'b1;
    for (int c = 1; c <= SMP_C + 20; c++) begin
      @(negedge clk);
      if (b && c == 4) m_low = 1'b0;
      if (rx_valid) begin
        got = c;
        gb = rx_bit;
      end
    end
    m_low = 1'b0;
    idle(20);
    chk(got == SYNC + SMP_C, "R4", "rx_valid timing", got, SYNC + SMP_C);
    chk(gb === b, "R4", "rx_bit value", int'(gb), int'(b));
    chk(n_rx == r0 + 1, "R8", "one rx pulse per slot", n_rx - r0, 1);
  endtask

  task automatic t_read(input logic b);
    int t0, take_c, first_on, last_on;
    logic seen;
    take_c = -1; first_on = 0; last_on = 0; seen = 1'bx;
    tx_mode = 1'b1;
    tx_bit = b;
    t0 = n_tx;
    m_low = 1'b1;
    for (int c = 1; c <= SYNC + HLD_C + 10; c++) begin
      @(negedge clk);
      if (c == 4) m_low = 1'b0;
      if (tx_taken) take_c = c;
      if (dq_pull && first_on == 0) first_on = c;
      if (dq_pull) last_on = c;
      if (c == 15 * CPU) seen = dq_line;
    end
    idle(20);
    if (!b) begin
      chk(take_c == SYNC, "R5", "take pulse timing", take_c, SYNC);
      chk(first_on == SYNC, "R5", "pull start", first_on, SYNC);
      chk(last_on == SYNC + HLD_C - 1, "R5", "pull last cycle", last_on, SYNC + HLD_C - 1);
      chk(seen === 1'b0, "R5", "line at 15us", int'(seen), 0);
    end else begin
      chk(take_c == SYNC, "R6", "take pulse timing", take_c, SYNC);
      chk(first_on == 0, "R6", "no pull for a 1", first_on, 0);
      chk(seen === 1'b1, "R6", "line at 15us", int'(seen), 1);
    end
    chk(n_tx == t0 + 1, "R8", "one take pulse per slot", n_tx - t0, 1);
    tx_mode = 1'b0;
  endtask

  task automatic t_short_low();
    int b0, r0;
    tx_mode = 1'b0;
    b0 = n_br; r0 = n_rx;
    m_low = 1'b1;
    idle(RST_C - 10);
    m_low = 1'b0;
    idle(20);
    chk(n_br == b0, "R2", "short low gives no bus_reset", n_br - b0, 0);
    chk(n_rx == r0 + 1, "R8", "long write 0 gives one rx", n_rx - r0, 1);
  endtask

  task automatic t_reset_in_slot();
    tx_mode = 1'b1;
    tx_bit = 1'b0;
    t_bus_reset("during read slot R7");
    tx_mode = 1'b0;
    t_write(1'b1);
  endtask

  task automatic t_fall_in_presence();
    int c, r0, t0, rise_c;
    rise_c = -1;
    m_low = 1'b1;
    wait_sig(0, 1'b1, RST_C + 50, c);
    idle(20);
    tx_mode = 1'b1;
    tx_bit = 1'b0;
    r0 = n_rx; t0 = n_tx;
    m_low = 1'b0;
    for (int i = 1; i <= SYNC + PDH_C + PDL_C + 20; i++) begin
      @(negedge clk);
      if (i == 10) m_low = 1'b1;
      if (i == 14) m_low = 1'b0;
      if (dq_pull && rise_c < 0) rise_c = i;
    end
    idle(20);
    chk(rise_c == SYNC + PDH_C, "R8", "presence kept despite edge in gap", rise_c, SYNC + PDH_C);
    chk(n_rx == r0 && n_tx == t0, "R8", "no slot during presence", (n_rx - r0) + (n_tx - t0), 0);
    tx_mode = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_bus_reset("first");
    t_write(1'b1);
    t_write(1'b0);
    t_read(1'b0);
    t_read(1'b1);
    t_write(1'b0);
    t_short_low();
    t_reset_in_slot();
    t_fall_in_presence();
    t_read(1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule